// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block forms a 32-bit linear address from a 16-bit segment selector and an effective offset, as the address stage of a CPU core that runs in real-mode style. The segment base is the selector multiplied by sixteen. No descriptor is looked up. In the normal 16-bit form, the offset is the sum of up to three terms, each chosen by a small select field: an optional base register (BX or BP), an optional index register (SI or DI), and a displacement. The displacement can be absent, an 8-bit value that is sign-extended, or a full 16-bit value.

A wide-offset prefix input replaces the base/index form with a 32-bit offset supplied directly. In that form the block checks the offset against the 64 KB segment limit and raises a fault flag, but it still produces the address. The base is added in full 32-bit precision. A high selector therefore reaches the area just above 1 MB instead of wrapping to zero.

Inputs are captured on a valid strobe, and the result appears one clock later.

Top module: `rm_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `lin_addr`, `out_valid` and `limit_fault` are all cleared to zero.
- R2: `out_valid` is high in the cycle after a clock edge that samples `in_valid` high, and low after an edge that samples it low.
- R3: The segment base is `seg_sel` shifted left by 4 and is added to the offset in 32 bits without wrapping at 1 MB. Selector 0xFFFF with offset 0xFFFF gives 0x0010FFEF, and with offset 0x0010 it gives 0x00100000.
- R4: `base_pick` encoding: 0 or 3 adds no base term, 1 adds `reg_bx`, 2 adds `reg_bp`.
- R5: `idx_pick` encoding: 0 or 3 adds no index term, 1 adds `reg_si`, 2 adds `reg_di`.
- R6: `disp_mode` encoding: 0 adds no displacement, 1 adds `disp_in[7:0]` sign-extended to 16 bits (bits 15:8 have no effect), and 2 or 3 adds all 16 bits of `disp_in`.
- R7: In 16-bit form the sum of base, index and displacement wraps modulo 65536 before the segment base is added.
- R8: With `in_wide` high the offset is `off_wide`, and the base, index and displacement inputs have no effect. The linear address is the segment base plus `off_wide` modulo 2^32.
- R9: `limit_fault` is 1 exactly when a wide-form offset exceeds 0xFFFF, and the address is still produced. A 16-bit-form result always has `limit_fault` 0.
- R10: When `in_valid` is low at an edge, `lin_addr` and `limit_fault` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the operand inputs |
| in_wide | input | 1 | Wide-offset prefix: use `off_wide` as the offset |
| seg_sel | input | 16 | Segment selector |
| reg_bx | input | 16 | BX base register value |
| reg_bp | input | 16 | BP base register value |
| reg_si | input | 16 | SI index register value |
| reg_di | input | 16 | DI index register value |
| disp_in | input | 16 | Displacement |
| base_pick | input | 2 | Base register select |
| idx_pick | input | 2 | Index register select |
| disp_mode | input | 2 | Displacement form select |
| off_wide | input | 32 | 32-bit offset for the wide form |
| lin_addr | output | 32 | Linear address |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| limit_fault | output | 1 | Offset exceeded the 64 KB segment limit |

## Verification
The bench covers several corner cases, each tied to the fault it would expose:

- **High selector with a large offset.** A design that truncated the sum to 20 bits would land near zero instead of at 0x10FFEF.
- **Offset sum that overflows 16 bits.** A design that carried into bit 16 would push the address 64 KB too far.
- **Negative 8-bit displacement with junk in the upper byte.** A design that zero-extended the byte, or used the whole word, would give the wrong address.
- **Wide-form offsets on either side of 0xFFFF.** These catch an off-by-one comparator, a fault that leaks into the 16-bit form, and a wide path that still adds the register terms.
- **Idle cycles.** The bench checks that the outputs hold and that the strobe drops.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;

   typedef enum logic [1:0] {
      BASE_NONE = 2'd0,
      BASE_BX   = 2'd1,
      BASE_BP   = 2'd2,
      BASE_RSV  = 2'd3
   } base_pick_e;

   typedef enum logic [1:0] {
      IDX_NONE = 2'd0,
      IDX_SI   = 2'd1,
      IDX_DI   = 2'd2,
      IDX_RSV  = 2'd3
   } idx_pick_e;

   typedef enum logic [1:0] {
      DSP_NONE   = 2'd0,
      DSP_NARROW = 2'd1,
      DSP_FULL   = 2'd2,
      DSP_FULL_B = 2'd3
   } disp_mode_e;

endpackage

// File: rtl/rm_ofs16.sv
module rm_ofs16
   import rm_addr_pkg::*;
#(
   parameter int OFF_W    = 16,
   parameter int NARROW_W = 8
) (
   input  logic [OFF_W-1:0] reg_bx,
   input  logic [OFF_W-1:0] reg_bp,
   input  logic [OFF_W-1:0] reg_si,
   input  logic [OFF_W-1:0] reg_di,
   input  logic [OFF_W-1:0] disp_in,
   input  base_pick_e       base_pick,
   input  idx_pick_e        idx_pick,
   input  disp_mode_e       disp_mode,
   output logic [OFF_W-1:0] ofs
);

   localparam int EXT_BITS = OFF_W - NARROW_W;

   if (NARROW_W < 1 || NARROW_W >= OFF_W) begin : g_bad_narrow
      $error("rm_ofs16: NARROW_W must be between 1 and OFF_W-1");
   end

   logic [OFF_W-1:0] base_term;
   logic [OFF_W-1:0] idx_term;
   logic [OFF_W-1:0] disp_term;
   logic [OFF_W-1:0] narrow_ext;

   assign narrow_ext = {{EXT_BITS{disp_in[NARROW_W-1]}}, disp_in[NARROW_W-1:0]};

   always_comb begin
      unique case (base_pick)
         BASE_BX: base_term = reg_bx;
         BASE_BP: base_term = reg_bp;
         default: base_term = '0;
      endcase
      unique case (idx_pick)
         IDX_SI:  idx_term = reg_si;
         IDX_DI:  idx_term = reg_di;
         default: idx_term = '0;
      endcase
      unique case (disp_mode)
         DSP_NONE:   disp_term = '0;
         DSP_NARROW: disp_term = narrow_ext;
         default:    disp_term = disp_in;
      endcase
   end

   // sum truncates to OFF_W bits: modular wrap inside the segment
   assign ofs = base_term + idx_term + disp_term;

endmodule

// File: rtl/rm_seg_base.sv
module rm_seg_base #(
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int LIN_W     = 32
) (
   input  logic [SEG_W-1:0] seg_sel,
   output logic [LIN_W-1:0] seg_base
);

   localparam int BASE_W = SEG_W + SEG_SHIFT;

   if (BASE_W > LIN_W) begin : g_bad_width
      $error("rm_seg_base: shifted selector does not fit LIN_W");
   end

   assign seg_base = LIN_W'({seg_sel, {SEG_SHIFT{1'b0}}});

endmodule

// File: rtl/rm_lim_chk.sv
module rm_lim_chk #(
   parameter int          EXT_W = 32,
   parameter int          OFF_W = 16,
   parameter int unsigned LIMIT = 32'h0000_FFFF
) (
   input  logic [EXT_W-1:0] ofs,
   output logic             over
);

   localparam logic [EXT_W-1:0] LIM_V   = EXT_W'(LIMIT);
   localparam logic [EXT_W-1:0] ALL_ONE = EXT_W'((64'd1 << OFF_W) - 64'd1);

   if (EXT_W <= OFF_W) begin : g_bad_width
      $error("rm_lim_chk: EXT_W must exceed OFF_W");
   end

   if (LIM_V == ALL_ONE) begin : g_pow2
      // limit is a full power-of-two span: any upper bit set overflows
      assign over = |ofs[EXT_W-1:OFF_W];
   end else begin : g_cmp
      assign over = ofs > LIM_V;
   end

endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen
   import rm_addr_pkg::*;
#(
   parameter int          SEG_W     = 16,
   parameter int          OFF_W     = 16,
   parameter int          EXT_W     = 32,
   parameter int          LIN_W     = 32,
   parameter int          SEG_SHIFT = 4,
   parameter int          NARROW_W  = 8,
   parameter int unsigned LIMIT     = 32'h0000_FFFF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_wide,
   input  logic [15:0]      seg_sel,
   input  logic [15:0]      reg_bx,
   input  logic [15:0]      reg_bp,
   input  logic [15:0]      reg_si,
   input  logic [15:0]      reg_di,
   input  logic [15:0]      disp_in,
   input  logic [1:0]       base_pick,
   input  logic [1:0]       idx_pick,
   input  logic [1:0]       disp_mode,
   input  logic [31:0]      off_wide,
   output logic [31:0]      lin_addr,
   output logic             out_valid,
   output logic             limit_fault
);

   if (SEG_W != 16 || OFF_W != 16 || EXT_W != 32 || LIN_W != 32) begin : g_bad_port
      $error("rm_addr_gen: port widths are fixed at 16/16/32/32");
   end
   if (EXT_W > LIN_W) begin : g_bad_ext
      $error("rm_addr_gen: EXT_W must not exceed LIN_W");
   end

   logic [OFF_W-1:0] ofs16;
   logic [LIN_W-1:0] seg_base;
   logic [EXT_W-1:0] ofs_sel;
   logic             over;
   logic [LIN_W-1:0] sum_nx;

   rm_ofs16 #(.OFF_W(OFF_W), .NARROW_W(NARROW_W)) ofs_i (
      .reg_bx    (reg_bx),
      .reg_bp    (reg_bp),
      .reg_si    (reg_si),
      .reg_di    (reg_di),
      .disp_in   (disp_in),
      .base_pick (base_pick_e'(base_pick)),
      .idx_pick  (idx_pick_e'(idx_pick)),
      .disp_mode (disp_mode_e'(disp_mode)),
      .ofs       (ofs16)
   );

   rm_seg_base #(.SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT), .LIN_W(LIN_W)) seg_i (
      .seg_sel  (seg_sel),
      .seg_base (seg_base)
   );

   assign ofs_sel = in_wide ? off_wide : EXT_W'(ofs16);

   rm_lim_chk #(.EXT_W(EXT_W), .OFF_W(OFF_W), .LIMIT(LIMIT)) lim_i (
      .ofs  (ofs_sel),
      .over (over)
   );

   assign sum_nx = seg_base + LIN_W'(ofs_sel);

   always_ff @(posedge clk) begin
      if (rst) begin
         lin_addr    <= '0;
         out_valid   <= 1'b0;
         limit_fault <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            lin_addr    <= sum_nx;
            limit_fault <= in_wide & over;
         end
      end
   end

   // R2
   valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R9
   fault_wide_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid && !in_wide |=> !limit_fault);

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(lin_addr) && $stable(limit_fault));

   // R3
   range16_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid && !in_wide |=>
         (lin_addr - (32'($past(seg_sel)) << 4)) <= 32'h0000_FFFF);

endmodule

// File: tb/rm_addr_gen_tb_top.sv
`timescale 1ns/1ps
module rm_addr_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid, in_wide;
   logic [15:0] seg_sel, reg_bx, reg_bp, reg_si, reg_di, disp_in;
   logic [1:0]  base_pick, idx_pick, disp_mode;
   logic [31:0] off_wide;
   logic [31:0] lin_addr;
   logic        out_valid, limit_fault;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   rm_addr_gen dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
      .seg_sel(seg_sel), .reg_bx(reg_bx), .reg_bp(reg_bp),
      .reg_si(reg_si), .reg_di(reg_di), .disp_in(disp_in),
      .base_pick(base_pick), .idx_pick(idx_pick), .disp_mode(disp_mode),
      .off_wide(off_wide), .lin_addr(lin_addr), .out_valid(out_valid),
      .limit_fault(limit_fault)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model(logic w, logic [15:0] s, logic [1:0] bp,
                                         logic [1:0] ip, logic [1:0] dm,
                                         logic [15:0] bxv, logic [15:0] bpv,
                                         logic [15:0] siv, logic [15:0] div,
                                         logic [15:0] d, logic [31:0] ow);
      logic [15:0] o;
      o = 16'h0;
      if (w) return {12'h0, s, 4'h0} + ow;
      if (bp == 2'd1) o = o + bxv;
      if (bp == 2'd2) o = o + bpv;
      if (ip == 2'd1) o = o + siv;
      if (ip == 2'd2) o = o + div;
      if (dm == 2'd1) o = o + {{8{d[7]}}, d[7:0]};
      if (dm >= 2'd2) o = o + d;
      return {12'h0, s, 4'h0} + {16'h0, o};
   endfunction

   // drive at negedge, capture at posedge, observe at following negedge
   task automatic issue(string req, logic w, logic [15:0] s, logic [1:0] bp,
                        logic [1:0] ip, logic [1:0] dm, logic [15:0] d,
                        logic [31:0] ow, logic exp_fault);
      @(negedge clk);
      in_valid = 1'b1; in_wide = w; seg_sel = s; base_pick = bp;
      idx_pick = ip; disp_mode = dm; disp_in = d; off_wide = ow;
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " addr"}, lin_addr,
          model(w, s, bp, ip, dm, reg_bx, reg_bp, reg_si, reg_di, d, ow));
      chk({req, " fault"}, {31'h0, limit_fault}, {31'h0, exp_fault});
      chk("R2 valid", {31'h0, out_valid}, 32'h1);
   endtask

   task automatic t_reset();
      chk("R1 addr", lin_addr, 32'h0);
      chk("R1 valid", {31'h0, out_valid}, 32'h0);
      chk("R1 fault", {31'h0, limit_fault}, 32'h0);
   endtask

   task automatic t_regs();
      reg_bx = 16'h0100; reg_bp = 16'h0200; reg_si = 16'h0020; reg_di = 16'h0040;
      issue("R4 R5 bx+si", 1'b0, 16'h1234, 2'd1, 2'd1, 2'd2, 16'h0003, 32'h0, 1'b0);
      issue("R4 R5 bp+di", 1'b0, 16'h1234, 2'd2, 2'd2, 2'd0, 16'hAAAA, 32'h0, 1'b0);
      issue("R4 R5 none", 1'b0, 16'h0800, 2'd3, 2'd0, 2'd3, 16'h0777, 32'h0, 1'b0);
      chk("R4 R5 none exact", lin_addr, 32'h0000_8777);
   endtask

   task automatic t_disp();
      reg_bx = 16'h1000;
      issue("R6 disp8 neg", 1'b0, 16'h0000, 2'd1, 2'd0, 2'd1, 16'h12F0, 32'h0, 1'b0);
      chk("R6 disp8 neg exact", lin_addr, 32'h0000_0FF0);
      issue("R6 disp8 pos", 1'b0, 16'h0000, 2'd1, 2'd0, 2'd1, 16'hFF7F, 32'h0, 1'b0);
      chk("R6 disp8 pos exact", lin_addr, 32'h0000_107F);
   endtask

   task automatic t_wrap();
      reg_bx = 16'hFFFF; reg_si = 16'h0002;
      issue("R7 wrap", 1'b0, 16'h2000, 2'd1, 2'd1, 2'd0, 16'h0, 32'h0, 1'b0);
      chk("R7 wrap exact", lin_addr, 32'h0002_0001);
   endtask

   task automatic t_high();
      issue("R3 top", 1'b0, 16'hFFFF, 2'd0, 2'd0, 2'd2, 16'hFFFF, 32'h0, 1'b0);
      chk("R3 top exact", lin_addr, 32'h0010_FFEF);
      issue("R3 edge", 1'b0, 16'hFFFF, 2'd0, 2'd0, 2'd2, 16'h0010, 32'h0, 1'b0);
      chk("R3 edge exact", lin_addr, 32'h0010_0000);
   endtask

   task automatic t_wide();
      reg_bx = 16'h5555; reg_si = 16'h3333;
      issue("R8 R9 over", 1'b1, 16'h0100, 2'd1, 2'd1, 2'd2, 16'h1111, 32'h0001_2345, 1'b1);
      chk("R8 exact", lin_addr, 32'h0001_3345);
      issue("R9 at limit", 1'b1, 16'h0100, 2'd1, 2'd1, 2'd2, 16'h1111, 32'h0000_FFFF, 1'b0);
      issue("R9 just over", 1'b1, 16'h0000, 2'd0, 2'd0, 2'd0, 16'h0, 32'h0001_0000, 1'b1);
      issue("R8 mod wrap", 1'b1, 16'hF000, 2'd0, 2'd0, 2'd0, 16'h0, 32'hFFFF_0000, 1'b1);
      issue("R9 narrow clear", 1'b0, 16'h0000, 2'd1, 2'd0, 2'd0, 16'h0, 32'hFFFF_FFFF, 1'b0);
   endtask

   task automatic t_hold();
      logic [31:0] prev;
      issue("R10 setup", 1'b1, 16'h0010, 2'd0, 2'd0, 2'd0, 16'h0, 32'h0002_0000, 1'b1);
      prev = lin_addr;
      @(negedge clk);
      in_wide = 1'b0; seg_sel = 16'h9999; off_wide = 32'h0; disp_mode = 2'd2;
      @(negedge clk);
      @(negedge clk);
      chk("R10 addr hold", lin_addr, prev);
      chk("R10 fault hold", {31'h0, limit_fault}, 32'h1);
      chk("R2 valid low", {31'h0, out_valid}, 32'h0);
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_wide = 1'b0; seg_sel = '0;
      reg_bx = '0; reg_bp = '0; reg_si = '0; reg_di = '0; disp_in = '0;
      base_pick = '0; idx_pick = '0; disp_mode = '0; off_wide = '0;
      repeat (4) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_regs();
      t_disp();
      t_wrap();
      t_high();
      t_wide();
      t_hold();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      t_reset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule